// File: doc/BRIEF.md
# Base-Bounds Address Translation Unit

This unit turns a 32-bit virtual address into a physical address for a small processor core that has no TLB. Each request carries the address, the kind of access (fetch, load or store) and the privilege level of the requester. The top half of the address space belongs to the kernel and is translated by fixed rules. The bottom half is the relocatable user region. Addresses in the user region are compared against a limit and then offset by a per-stream base. Instruction fetches use one base/limit pair. Loads and stores use a second pair.

Every request produces a registered response on the following clock. The response holds either a physical address with a cacheability flag, or an exception strobe with a two-bit cause. Software, or the surrounding core, loads the four relocation registers through a simple write port. The reset input is asynchronous and active low. Its release is synchronised inside the unit, so the unit leaves reset two clock edges after the input rises.

Top module: `bb_xlate_unit`

## Requirements
- R1: After reset, rsp_valid and rsp_exc are 0 and rsp_cause is 2'b00. All four relocation registers are 0, so every user-region request faults until a limit is written.
- R2: A request presented with req_valid high on one rising edge gets its response on the outputs after that edge. rsp_valid is 1 then. A cycle with req_valid low gives rsp_valid 0 and rsp_exc 0.
- R3: A user-region address (bit 31 = 0) that passes the limit check yields rsp_paddr = vaddr + base, with rsp_cacheable = 1 and rsp_exc = 0.
- R4: A user-region address passes only when vaddr < limit, compared unsigned. An address equal to or above the limit sets rsp_exc = 1, rsp_paddr = 0 and rsp_cacheable = 0.
- R5: req_kind 2'b00 (fetch) uses the instruction pair, and a limit fault on it gives cause 2'b01. req_kind 2'b01 (load), 2'b10 (store) and 2'b11 (treated as a load) use the data pair, and a limit fault on them gives cause 2'b10.
- R6: In kernel mode, addresses 0x80000000–0x9FFFFFFF map to the address with its top three bits cleared, with rsp_cacheable = 1.
- R7: In kernel mode, addresses 0xA0000000–0xBFFFFFFF map to the address with its top three bits cleared, with rsp_cacheable = 0.
- R8: In kernel mode, addresses 0xC0000000–0xFFFFFFFF map to the same physical address, with rsp_cacheable = 1.
- R9: A user-mode (req_user = 1) access to any address with bit 31 set gives rsp_exc = 1 and cause 2'b11, whatever the access kind.
- R10: When cfg_we is 1, the edge loads cfg_wdata into the register chosen by cfg_sel: 2'b00 instruction base, 2'b01 instruction limit, 2'b10 data base, 2'b11 data limit. A request on that same edge still sees the old value.
- R11: Kernel-region translations do not depend on the relocation registers.
- R12: The sum vaddr + base wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 load |
| req_user | input | 1 | 1 = user privilege, 0 = kernel |
| cfg_we | input | 1 | Relocation register write enable |
| cfg_sel | input | 2 | Register select: 00 ibase, 01 ilimit, 10 dbase, 11 dlimit |
| cfg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address (0 on exception) |
| rsp_cacheable | output | 1 | Target may be cached |
| rsp_exc | output | 1 | Exception strobe |
| rsp_cause | output | 2 | 00 none, 01 fetch limit, 10 data limit, 11 privilege |

## Verification
The properties assume that req_kind, req_user and req_vaddr are stable and known on every edge where req_valid is high. They also assume that the synchronised reset is the reference point, so nothing is checked before the unit leaves reset. The bench drives all inputs on the falling edge and holds them to the next falling edge. It waits for the synchronised reset to release before issuing requests, and it never leaves req_kind or the address undefined while a request is pending. The properties pin down the kernel-region mappings and the cause encodings. The limit arithmetic and the register-write timing depend on the loaded register values, so the bench checks those against values it computes itself.

// File: rtl/bb_xlate_pkg.sv
package bb_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_ALT   = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_IFETCH = 2'b01,
    CAUSE_DATA   = 2'b10,
    CAUSE_PRIV   = 2'b11
  } exc_cause_e;

  typedef enum logic [1:0] {
    SEG_USER    = 2'b00,
    SEG_KCACHED = 2'b01,
    SEG_KRAW    = 2'b10,
    SEG_KHIGH   = 2'b11
  } seg_kind_e;

  localparam int STREAM_INSN = 0;
  localparam int STREAM_DATA = 1;

endpackage

// File: rtl/bb_seg_decode.sv
module bb_seg_decode
  import bb_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  output seg_kind_e         seg,
  output logic [ADDR_W-1:0] kern_paddr,
  output logic              kern_cacheable
);

  localparam int TOP_BITS = 3;
  localparam int LOW_W    = ADDR_W - TOP_BITS;

  logic [TOP_BITS-1:0] top_bits;

  always_comb begin
    top_bits = vaddr[ADDR_W-1 -: TOP_BITS];
    if (!top_bits[TOP_BITS-1]) begin
      seg = SEG_USER;
    end else if (top_bits[TOP_BITS-2]) begin
      seg = SEG_KHIGH;
    end else if (top_bits[TOP_BITS-3]) begin
      seg = SEG_KRAW;
    end else begin
      seg = SEG_KCACHED;
    end
  end

  always_comb begin
    kern_paddr     = '0;
    kern_cacheable = 1'b0;
    unique case (seg)
      SEG_KCACHED: begin
        kern_paddr     = {{TOP_BITS{1'b0}}, vaddr[LOW_W-1:0]};
        kern_cacheable = 1'b1;
      end
      SEG_KRAW: begin
        kern_paddr     = {{TOP_BITS{1'b0}}, vaddr[LOW_W-1:0]};
        kern_cacheable = 1'b0;
      end
      SEG_KHIGH: begin
        kern_paddr     = vaddr;
        kern_cacheable = 1'b1;
      end
      default: begin
        kern_paddr     = '0;
        kern_cacheable = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bb_reloc_regs.sv
module bb_reloc_regs #(
  parameter int ADDR_W      = 32,
  parameter int NUM_STREAMS = 2,
  localparam int STR_W      = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STR_W-1:0]  wr_stream,
  input  logic              wr_is_limit,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [STR_W-1:0]  rd_stream,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_limit
);

  logic [ADDR_W-1:0] base_q  [NUM_STREAMS];
  logic [ADDR_W-1:0] limit_q [NUM_STREAMS];

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    logic              base_en;
    logic              limit_en;
    logic [ADDR_W-1:0] base_d;
    logic [ADDR_W-1:0] limit_d;

    always_comb begin
      base_en  = wr_en && (wr_stream == STR_W'(s)) && !wr_is_limit;
      limit_en = wr_en && (wr_stream == STR_W'(s)) &&  wr_is_limit;
      base_d   = base_en  ? wr_data : base_q[s];
      limit_d  = limit_en ? wr_data : limit_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[s]  <= '0;
        limit_q[s] <= '0;
      end else begin
        base_q[s]  <= base_d;
        limit_q[s] <= limit_d;
      end
    end
  end

  always_comb begin
    rd_base  = '0;
    rd_limit = '0;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      if (rd_stream == STR_W'(s)) begin
        rd_base  = base_q[s];
        rd_limit = limit_q[s];
      end
    end
  end

endmodule

// File: rtl/bb_limit_check.sv
module bb_limit_check #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              in_range,
  output logic [ADDR_W-1:0] reloc_paddr
);

  always_comb begin
    in_range    = (vaddr < limit);
    reloc_paddr = vaddr + base;
  end

endmodule

// File: rtl/bb_xlate_unit.sv
module bb_xlate_unit
  import bb_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_cacheable,
  output logic              rsp_exc,
  output logic [1:0]        rsp_cause
);

  localparam int NUM_STREAMS = 2;
  localparam int STR_W       = 1;
  localparam int SYNC_STAGES = 2;

  // reset release synchroniser
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  // segment decode
  seg_kind_e         seg;
  logic [ADDR_W-1:0] kern_paddr;
  logic              kern_cacheable;

  bb_seg_decode #(.ADDR_W(ADDR_W)) u_seg (
    .vaddr          (req_vaddr),
    .seg            (seg),
    .kern_paddr     (kern_paddr),
    .kern_cacheable (kern_cacheable)
  );

  // relocation registers
  logic              is_fetch;
  logic [STR_W-1:0]  rd_stream;
  logic [ADDR_W-1:0] sel_base;
  logic [ADDR_W-1:0] sel_limit;

  always_comb begin
    is_fetch  = (acc_kind_e'(req_kind) == ACC_FETCH);
    rd_stream = is_fetch ? STR_W'(STREAM_INSN) : STR_W'(STREAM_DATA);
  end

  bb_reloc_regs #(.ADDR_W(ADDR_W), .NUM_STREAMS(NUM_STREAMS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (cfg_we),
    .wr_stream   (cfg_sel[1]),
    .wr_is_limit (cfg_sel[0]),
    .wr_data     (cfg_wdata),
    .rd_stream   (rd_stream),
    .rd_base     (sel_base),
    .rd_limit    (sel_limit)
  );

  // limit check and relocation
  logic              in_range;
  logic [ADDR_W-1:0] reloc_paddr;

  bb_limit_check #(.ADDR_W(ADDR_W)) u_chk (
    .vaddr       (req_vaddr),
    .base        (sel_base),
    .limit       (sel_limit),
    .in_range    (in_range),
    .reloc_paddr (reloc_paddr)
  );

  // next-state
  logic              valid_d;
  logic [ADDR_W-1:0] paddr_d;
  logic              cache_d;
  logic              exc_d;
  exc_cause_e        cause_d;

  always_comb begin
    valid_d = req_valid;
    paddr_d = '0;
    cache_d = 1'b0;
    exc_d   = 1'b0;
    cause_d = CAUSE_NONE;
    if (req_valid) begin
      if (seg != SEG_USER) begin
        if (req_user) begin
          exc_d   = 1'b1;
          cause_d = CAUSE_PRIV;
        end else begin
          paddr_d = kern_paddr;
          cache_d = kern_cacheable;
        end
      end else if (in_range) begin
        paddr_d = reloc_paddr;
        cache_d = 1'b1;
      end else begin
        exc_d   = 1'b1;
        cause_d = is_fetch ? CAUSE_IFETCH : CAUSE_DATA;
      end
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_cacheable <= 1'b0;
      rsp_exc       <= 1'b0;
      rsp_cause     <= 2'b00;
    end else begin
      rsp_valid     <= valid_d;
      rsp_paddr     <= paddr_d;
      rsp_cacheable <= cache_d;
      rsp_exc       <= exc_d;
      rsp_cause     <= cause_d;
    end
  end

endmodule

// File: rtl/bb_xlate_chk.sv
module bb_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [1:0]        req_kind,
  input logic              req_user,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_cacheable,
  input logic              rsp_exc,
  input logic [1:0]        rsp_cause
);

  localparam int LOW_W = ADDR_W - 3;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!rsp_valid && !rsp_exc));

  p_req_answered_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  p_fault_clean_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_exc |-> (rsp_valid && !rsp_cacheable && rsp_paddr == '0 && rsp_cause != 2'b00));

  p_data_cause_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_vaddr[ADDR_W-1] && req_kind != 2'b00)
      |=> (!rsp_exc || rsp_cause == 2'b10));

  p_kcached_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_user && req_vaddr[ADDR_W-1 -: 3] == 3'b100)
      |=> (!rsp_exc && rsp_cacheable &&
           rsp_paddr == {3'b000, $past(req_vaddr[LOW_W-1:0])}));

  p_kraw_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_user && req_vaddr[ADDR_W-1 -: 3] == 3'b101)
      |=> (!rsp_exc && !rsp_cacheable &&
           rsp_paddr == {3'b000, $past(req_vaddr[LOW_W-1:0])}));

  p_khigh_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_user && req_vaddr[ADDR_W-1 -: 2] == 2'b11)
      |=> (!rsp_exc && rsp_cacheable && rsp_paddr == $past(req_vaddr)));

  p_priv_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_user && req_vaddr[ADDR_W-1])
      |=> (rsp_exc && rsp_cause == 2'b11));

endmodule

bind bb_xlate_unit bb_xlate_chk #(.ADDR_W(ADDR_W)) u_bb_xlate_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .req_valid     (req_valid),
  .req_vaddr     (req_vaddr),
  .req_kind      (req_kind),
  .req_user      (req_user),
  .rsp_valid     (rsp_valid),
  .rsp_paddr     (rsp_paddr),
  .rsp_cacheable (rsp_cacheable),
  .rsp_exc       (rsp_exc),
  .rsp_cause     (rsp_cause)
);

// File: tb/tb_bb_xlate_unit.sv
module tb_bb_xlate_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // vector: kind[70:69] user[68] va[67:36] exc[35] cause[34:33] pa[32:1] cache[0]
  localparam int NV = 20;
  localparam logic [70:0] VEC [NV] = '{
    {2'd0, 1'b0, 32'h0000_0100, 1'b0, 2'd0, 32'h1000_0100, 1'b1}, // R3 fetch kernel
    {2'd0, 1'b1, 32'h000F_FFFF, 1'b0, 2'd0, 32'h100F_FFFF, 1'b1}, // R4 limit-1
    {2'd0, 1'b1, 32'h0010_0000, 1'b1, 2'd1, 32'h0000_0000, 1'b0}, // R4 equal limit
    {2'd1, 1'b1, 32'h0000_7FFC, 1'b0, 2'd0, 32'h2000_7FFC, 1'b1}, // R3 load
    {2'd2, 1'b1, 32'h0000_8000, 1'b1, 2'd2, 32'h0000_0000, 1'b0}, // R4 store at limit
    {2'd2, 1'b1, 32'h0000_0004, 1'b0, 2'd0, 32'h2000_0004, 1'b1}, // R3 store
    {2'd3, 1'b1, 32'h0000_8000, 1'b1, 2'd2, 32'h0000_0000, 1'b0}, // R5 kind 11 data
    {2'd3, 1'b1, 32'h0000_0010, 1'b0, 2'd0, 32'h2000_0010, 1'b1}, // R5 kind 11 data
    {2'd0, 1'b1, 32'h0005_0000, 1'b0, 2'd0, 32'h1005_0000, 1'b1}, // R5 fetch pair
    {2'd1, 1'b1, 32'h0005_0000, 1'b1, 2'd2, 32'h0000_0000, 1'b0}, // R5 data pair
    {2'd1, 1'b0, 32'h8000_1234, 1'b0, 2'd0, 32'h0000_1234, 1'b1}, // R6
    {2'd0, 1'b0, 32'h9FFF_FFFF, 1'b0, 2'd0, 32'h1FFF_FFFF, 1'b1}, // R6 top
    {2'd2, 1'b0, 32'hA000_0040, 1'b0, 2'd0, 32'h0000_0040, 1'b0}, // R7
    {2'd1, 1'b0, 32'hBFFF_FFF0, 1'b0, 2'd0, 32'h1FFF_FFF0, 1'b0}, // R7 top
    {2'd1, 1'b0, 32'hC000_0000, 1'b0, 2'd0, 32'hC000_0000, 1'b1}, // R8
    {2'd0, 1'b0, 32'hFFFF_FFFC, 1'b0, 2'd0, 32'hFFFF_FFFC, 1'b1}, // R8 top
    {2'd1, 1'b1, 32'h8000_0000, 1'b1, 2'd3, 32'h0000_0000, 1'b0}, // R9 load
    {2'd0, 1'b1, 32'hFFFF_FFFF, 1'b1, 2'd3, 32'h0000_0000, 1'b0}, // R9 fetch
    {2'd2, 1'b1, 32'hA000_0000, 1'b1, 2'd3, 32'h0000_0000, 1'b0}, // R9 store
    {2'd0, 1'b0, 32'h0000_0000, 1'b0, 2'd0, 32'h1000_0000, 1'b1}  // R3 base only
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        req_user;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_cacheable;
  logic        rsp_exc;
  logic [1:0]  rsp_cause;

  int n_checks;
  int n_errors;
  int cycles;

  bb_xlate_unit dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_kind      (req_kind),
    .req_user      (req_user),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .cfg_wdata     (cfg_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_cacheable (rsp_cacheable),
    .rsp_exc       (rsp_exc),
    .rsp_cause     (rsp_cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_rsp(input string req, input logic exc, input logic [1:0] cause,
                           input logic [31:0] pa, input logic cache);
    check({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check({req, " exc"},   {31'd0, rsp_exc}, {31'd0, exc});
    check({req, " cause"}, {30'd0, rsp_cause}, {30'd0, cause});
    check({req, " paddr"}, rsp_paddr, pa);
    check({req, " cache"}, {31'd0, rsp_cacheable}, {31'd0, cache});
  endtask

  task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = sel;
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic issue(input logic [1:0] kind, input logic user, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = kind;
    req_user  = user;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    n_checks  = 0;
    n_errors  = 0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_kind  = 2'b00;
    req_user  = 1'b0;
    cfg_we    = 1'b0;
    cfg_sel   = 2'b00;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 exc",   {31'd0, rsp_exc}, 32'd0);
    check("R1 cause", {30'd0, rsp_cause}, 32'd0);

    // R1: zero limits fault every user-region access
    issue(2'b00, 1'b1, 32'h0000_0000);
    check_rsp("R1 zero ilimit", 1'b1, 2'd1, 32'h0, 1'b0);
    issue(2'b01, 1'b0, 32'h0000_0000);
    check_rsp("R1 zero dlimit", 1'b1, 2'd2, 32'h0, 1'b0);

    // R2: idle cycle gives no response
    @(negedge clk);
    check("R2 idle valid", {31'd0, rsp_valid}, 32'd0);
    check("R2 idle exc",   {31'd0, rsp_exc}, 32'd0);

    // R10: load relocation registers
    write_reg(2'b00, 32'h1000_0000);
    write_reg(2'b01, 32'h0010_0000);
    write_reg(2'b10, 32'h2000_0000);
    write_reg(2'b11, 32'h0000_8000);

    for (int i = 0; i < NV; i++) begin
      string tag;
      issue(VEC[i][70:69], VEC[i][68], VEC[i][67:36]);
      tag = $sformatf("vec%0d", i);
      check_rsp(tag, VEC[i][35], VEC[i][34:33], VEC[i][32:1], VEC[i][0]);
    end

    // R10: write and request on the same edge; request sees old limit
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = 2'b01;
    cfg_wdata = 32'h0000_0000;
    req_valid = 1'b1;
    req_kind  = 2'b00;
    req_user  = 1'b1;
    req_vaddr = 32'h0000_0100;
    @(negedge clk);
    cfg_we    = 1'b0;
    req_valid = 1'b0;
    check_rsp("R10 old limit", 1'b0, 2'd0, 32'h1000_0100, 1'b1);
    issue(2'b00, 1'b1, 32'h0000_0100);
    check_rsp("R10 new limit", 1'b1, 2'd1, 32'h0, 1'b0);

    // R12: relocation wraps modulo 2^32
    write_reg(2'b10, 32'hF000_0000);
    write_reg(2'b11, 32'h7FFF_FFFF);
    issue(2'b01, 1'b1, 32'h1000_0010);
    check_rsp("R12 wrap", 1'b0, 2'd0, 32'h0000_0010, 1'b1);
    issue(2'b10, 1'b1, 32'h7FFF_FFFE);
    check_rsp("R12 wrap high", 1'b0, 2'd0, 32'h6FFF_FFFE, 1'b1);
    issue(2'b10, 1'b1, 32'h7FFF_FFFF);
    check_rsp("R4 max limit", 1'b1, 2'd2, 32'h0, 1'b0);

    // R11: kernel mappings unaffected by changed registers
    issue(2'b01, 1'b0, 32'h8000_0010);
    check_rsp("R11 kcached", 1'b0, 2'd0, 32'h0000_0010, 1'b1);
    issue(2'b00, 1'b0, 32'hA000_0010);
    check_rsp("R11 kraw", 1'b0, 2'd0, 32'h0000_0010, 1'b0);
    issue(2'b10, 1'b0, 32'hD000_0010);
    check_rsp("R11 khigh", 1'b0, 2'd0, 32'hD000_0010, 1'b1);

    // R1: reset mid-run clears outputs and registers
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'b01;
    req_user  = 1'b0;
    req_vaddr = 32'h8000_0000;
    rst_n     = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 async valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    issue(2'b01, 1'b1, 32'h0000_0010);
    check_rsp("R1 regs cleared", 1'b1, 2'd2, 32'h0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule